// File: doc/BRIEF.md
# LPDDR Power-Up Initialization Sequencer

This block sits on the controller side of a mobile low-power DDR memory and owns the command bus from power-good until the memory is ready for normal traffic. When `powerGood` rises, it enables the clock, then holds the bus in NOP for a stable-clock delay. It then sends one all-bank precharge, two auto-refresh commands and the two mode-register loads. Each command is separated from the next by its own minimum gap, and every cycle of a gap carries NOP. After the final gap it raises `initDone` and leaves the bus idle for the scheduler that takes over.

All delays are given in clock cycles through parameters. A parameter selects whether the extended mode register is loaded before or after the standard one. A second parameter lets the clock enable stay low during the stable-clock delay and rise a fixed setup time before the first command. Dropping `powerGood` at any point sends the block back to its idle state. The next rise runs the whole sequence again from the beginning.

Command codes on the pins are active low in the order {cs, ras, cas, we}: DESELECT = 1xxx (driven as 1111), NOP = 0111, PRECHARGE = 0010, AUTO REFRESH = 0001, LOAD MODE = 0000. All outputs are registered. Every gap parameter must be at least 2 and `ADDR_W` must exceed 10.

Top module: `lpddr_init_seq`

## Requirements
- R1: After reset, and while `powerGood` is low, the block drives DESELECT (1111), holds `cke` low and holds `initDone` low.
- R2: After `powerGood` rises, the bus carries NOP (0111) for exactly `STABLE_CYC` cycles before the first executable command. In the standard mode, `cke` is high from the first of those NOP cycles.
- R3: The executable commands appear in this order and no others: PRECHARGE (0010), AUTO REFRESH (0001), AUTO REFRESH (0001), LOAD MODE (0000), LOAD MODE (0000).
- R4: The command-to-command spacing is exactly `T_RP` cycles after the precharge, and `T_RFC` cycles after each refresh. After the first mode load it is `T_MRD` cycles.
- R5: Between the first NOP and `initDone`, every cycle without an executable command carries NOP with chip select low. DESELECT never appears in that interval.
- R6: The precharge drives address bit 10 high, with all other address bits low and bank 00. The standard mode load drives bank 00 with `modeReg` on the address. The extended mode load drives bank 10 with `extModeReg`. With `EMR_FIRST` = 0 the standard load comes first; with 1 the extended load comes first.
- R7: With `CKE_LATE` = 1, `cke` stays low during the stable-clock NOPs. It then rises exactly `T_IS` cycles before the precharge, and the bus keeps carrying NOP during those cycles.
- R8: `initDone` rises exactly `T_MRD` cycles after the second mode load. It then stays high, with `cke` high and the bus on NOP, for as long as `powerGood` stays high.
- R9: Lowering `powerGood` in any state brings the pins to the R1 state on the second clock edge. A later rise restarts the full sequence from the stable-clock delay.
- R10: Every executable command lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| powerGood | input | 1 | Supplies and clock stable; low forces re-initialization |
| modeReg | input | ADDR_W | Value loaded into the standard mode register |
| extModeReg | input | ADDR_W | Value loaded into the extended mode register |
| cmdCsN | output | 1 | Chip select, active low |
| cmdRasN | output | 1 | Row strobe, active low |
| cmdCasN | output | 1 | Column strobe, active low |
| cmdWeN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| cke | output | 1 | Clock enable to the memory |
| initDone | output | 1 | Initialization complete |

## Verification
A wrong sequencer state shows up on the command pins one clock after the state register takes it. Possible symptoms are a command that is skipped or repeated, a bank or address value on the wrong load, or a DESELECT inside a gap. A counter loaded with the wrong value cannot be seen until the gap it times ends. That gap then ends a few cycles early or late, so the bench compares the cycle stamp of each command against the stamp of the one before it. A fault in the restart path is visible two edges after `powerGood` falls, as `cke` or `initDone` still high.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL, CMD_NOP, CMD_PREA, CMD_REF, CMD_MRS, CMD_EMRS
  } cmdKind_e;

  typedef enum logic [2:0] {
    GAP_NONE, GAP_STABLE, GAP_SETUP, GAP_RP, GAP_RFC, GAP_MRD
  } gapSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     load;   // reload the wait counter this cycle
    gapSel_e  gap;    // which gap value to load
    cmdKind_e cmd;    // command to drive next cycle
    logic     ckeOn;  // clock enable level
    logic     ready;  // sequence complete
  } seqStrobe_t;

endpackage

// File: rtl/lpddr_init_ctrl.sv
module lpddr_init_ctrl
  import lpddr_init_pkg::*;
#(
  parameter bit CKE_LATE  = 1'b0,
  parameter bit EMR_FIRST = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerGood,
  input  logic       cntZero,
  output seqStrobe_t strb
);

  typedef enum logic [3:0] {
    S_IDLE, S_STABLE, S_SETUP, S_PRE, S_WPRE, S_REF1, S_WREF1,
    S_REF2, S_WREF2, S_MRA, S_WMRA, S_MRB, S_WMRB, S_DONE
  } state_e;

  state_e state, nextState;

  localparam cmdKind_e FIRST_MR  = EMR_FIRST ? CMD_EMRS : CMD_MRS;
  localparam cmdKind_e SECOND_MR = EMR_FIRST ? CMD_MRS  : CMD_EMRS;

  always_comb begin
    nextState = state;
    unique case (state)
      S_IDLE:   nextState = S_STABLE;
      S_STABLE: if (cntZero) nextState = CKE_LATE ? S_SETUP : S_PRE;
      S_SETUP:  if (cntZero) nextState = S_PRE;
      S_PRE:    nextState = S_WPRE;
      S_WPRE:   if (cntZero) nextState = S_REF1;
      S_REF1:   nextState = S_WREF1;
      S_WREF1:  if (cntZero) nextState = S_REF2;
      S_REF2:   nextState = S_WREF2;
      S_WREF2:  if (cntZero) nextState = S_MRA;
      S_MRA:    nextState = S_WMRA;
      S_WMRA:   if (cntZero) nextState = S_MRB;
      S_MRB:    nextState = S_WMRB;
      S_WMRB:   if (cntZero) nextState = S_DONE;
      S_DONE:   nextState = S_DONE;
      default:  nextState = S_IDLE;
    endcase
    if (!powerGood) nextState = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb.load = (nextState != state);
    unique case (nextState)
      S_STABLE:        strb.gap = GAP_STABLE;
      S_SETUP:         strb.gap = GAP_SETUP;
      S_WPRE:          strb.gap = GAP_RP;
      S_WREF1, S_WREF2: strb.gap = GAP_RFC;
      S_WMRA, S_WMRB:  strb.gap = GAP_MRD;
      default:         strb.gap = GAP_NONE;
    endcase
    unique case (state)
      S_IDLE:        strb.cmd = CMD_DESEL;
      S_PRE:         strb.cmd = CMD_PREA;
      S_REF1, S_REF2: strb.cmd = CMD_REF;
      S_MRA:         strb.cmd = FIRST_MR;
      S_MRB:         strb.cmd = SECOND_MR;
      default:       strb.cmd = CMD_NOP;
    endcase
    strb.ckeOn = (state != S_IDLE) && !(CKE_LATE && state == S_STABLE);
    strb.ready = (state == S_DONE);
  end

  // R9
  pg_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    !powerGood |=> state == S_IDLE);

  // R4
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {S_WPRE, S_WREF1, S_WREF2, S_WMRA, S_WMRB}) && !cntZero && powerGood
    |=> state == $past(state));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE) && powerGood |=> state == S_DONE);

endmodule

// File: rtl/lpddr_init_dp.sv
module lpddr_init_dp
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int STABLE_CYC = 50000,
  parameter int T_IS       = 2,
  parameter int T_RP       = 4,
  parameter int T_RFC      = 20,
  parameter int T_MRD      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] modeReg,
  input  logic [ADDR_W-1:0] extModeReg,
  output logic              cntZero,
  output logic [3:0]        cmdPins,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              initDone
);

  localparam int MAX_A   = (STABLE_CYC > T_RFC) ? STABLE_CYC : T_RFC;
  localparam int MAX_B   = (T_IS > T_RP) ? T_IS : T_RP;
  localparam int MAX_GAP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int ALLBANK_BIT = 10;

  logic [CNT_W-1:0] cnt, loadVal;

  always_comb begin
    unique case (strb.gap)
      GAP_STABLE: loadVal = CNT_W'(STABLE_CYC - 1);
      GAP_SETUP:  loadVal = CNT_W'(T_IS - 1);
      GAP_RP:     loadVal = CNT_W'(T_RP - 2);
      GAP_RFC:    loadVal = CNT_W'(T_RFC - 2);
      GAP_MRD:    loadVal = CNT_W'(T_MRD - 2);
      default:    loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strb.load)      cnt <= loadVal;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPins  <= 4'b1111;
      ba       <= '0;
      addr     <= '0;
      cke      <= 1'b0;
      initDone <= 1'b0;
    end else begin
      ba   <= '0;
      addr <= '0;
      unique case (strb.cmd)
        CMD_DESEL: cmdPins <= 4'b1111;
        CMD_PREA: begin
          cmdPins            <= 4'b0010;
          addr[ALLBANK_BIT]  <= 1'b1;
        end
        CMD_REF:  cmdPins <= 4'b0001;
        CMD_MRS: begin
          cmdPins <= 4'b0000;
          addr    <= modeReg;
        end
        CMD_EMRS: begin
          cmdPins <= 4'b0000;
          ba      <= BA_W'(2);
          addr    <= extModeReg;
        end
        default:  cmdPins <= 4'b0111;
      endcase
      cke      <= strb.ckeOn;
      initDone <= strb.ready;
    end
  end

  logic cmdActive;
  assign cmdActive = !cmdPins[3] && (cmdPins[2:0] != 3'b111);

  // R2
  cke_for_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdActive |-> cke);

  // R10
  single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdActive |=> cmdPins[2:0] == 3'b111);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> cke && !cmdActive);

  // R4
  cnt_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntZero && !strb.load |=> cntZero);

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
  import lpddr_init_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int STABLE_CYC = 50000,
  parameter int T_IS       = 2,
  parameter int T_RP       = 4,
  parameter int T_RFC      = 20,
  parameter int T_MRD      = 2,
  parameter bit CKE_LATE   = 1'b0,
  parameter bit EMR_FIRST  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerGood,
  input  logic [ADDR_W-1:0] modeReg,
  input  logic [ADDR_W-1:0] extModeReg,
  output logic              cmdCsN,
  output logic              cmdRasN,
  output logic              cmdCasN,
  output logic              cmdWeN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic              initDone
);

  seqStrobe_t strb;
  logic       cntZero;
  logic [3:0] cmdPins;

  lpddr_init_ctrl #(
    .CKE_LATE (CKE_LATE),
    .EMR_FIRST(EMR_FIRST)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .powerGood(powerGood),
    .cntZero  (cntZero),
    .strb     (strb)
  );

  lpddr_init_dp #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .STABLE_CYC(STABLE_CYC),
    .T_IS      (T_IS),
    .T_RP      (T_RP),
    .T_RFC     (T_RFC),
    .T_MRD     (T_MRD)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .modeReg   (modeReg),
    .extModeReg(extModeReg),
    .cntZero   (cntZero),
    .cmdPins   (cmdPins),
    .ba        (ba),
    .addr      (addr),
    .cke       (cke),
    .initDone  (initDone)
  );

  assign {cmdCsN, cmdRasN, cmdCasN, cmdWeN} = cmdPins;

endmodule

// File: tb/sim_lpddr_init_seq.sv
module sim_lpddr_init_seq;

  localparam int AW   = 13;
  localparam int S    = 40;
  localparam int TRP  = 3;
  localparam int TRFC = 9;
  localparam int TMRD = 2;
  localparam int TIS  = 3;

  // expected command stream, shared by both instances
  localparam logic [3:0] EXP_CMD [5] = '{4'b0010, 4'b0001, 4'b0001, 4'b0000, 4'b0000};
  localparam int         EXP_GAP [5] = '{S, TRP, TRFC, TRFC, TMRD};
  // bank per command: u0 standard-first, u1 extended-first
  localparam logic [1:0] EXP_BA [2][5] = '{'{2'd0, 2'd0, 2'd0, 2'd0, 2'd2},
                                           '{2'd0, 2'd0, 2'd0, 2'd2, 2'd0}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerGood = 1'b0;
  logic [AW-1:0] modeReg = '0, extModeReg = '0;

  logic [3:0] cmd0, cmd1;
  logic [1:0] ba0, ba1;
  logic [AW-1:0] addr0, addr1;
  logic cke0, cke1, done0, done1;

  always #2 clk = ~clk;

  lpddr_init_seq #(.ADDR_W(AW), .STABLE_CYC(S), .T_IS(TIS), .T_RP(TRP),
    .T_RFC(TRFC), .T_MRD(TMRD), .CKE_LATE(1'b0), .EMR_FIRST(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .modeReg(modeReg),
    .extModeReg(extModeReg), .cmdCsN(cmd0[3]), .cmdRasN(cmd0[2]),
    .cmdCasN(cmd0[1]), .cmdWeN(cmd0[0]), .ba(ba0), .addr(addr0),
    .cke(cke0), .initDone(done0));

  lpddr_init_seq #(.ADDR_W(AW), .STABLE_CYC(S), .T_IS(TIS), .T_RP(TRP),
    .T_RFC(TRFC), .T_MRD(TMRD), .CKE_LATE(1'b1), .EMR_FIRST(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .powerGood(powerGood), .modeReg(modeReg),
    .extModeReg(extModeReg), .cmdCsN(cmd1[3]), .cmdRasN(cmd1[2]),
    .cmdCasN(cmd1[1]), .cmdWeN(cmd1[0]), .ba(ba1), .addr(addr1),
    .cke(cke1), .initDone(done1));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0;
  bit logEn = 1'b0;
  int nLog [2];
  logic [3:0] logCmd [2][8];
  logic [1:0] logBa [2][8];
  logic [AW-1:0] logAddr [2][8];
  int logCyc [2][8];
  int firstNop [2], ckeRise [2], doneRise [2], deselIn [2], postDone [2];
  logic prevCke [2];

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    for (int i = 0; i < 2; i++) begin
      nLog[i] = 0; firstNop[i] = -1; ckeRise[i] = -1; doneRise[i] = -1;
      deselIn[i] = 0; postDone[i] = 0; prevCke[i] = 1'b0;
    end
  endtask

  task automatic mon(int i, logic [3:0] c, logic [1:0] b, logic [AW-1:0] a,
                     logic k, logic d);
    if (!c[3] && c != 4'b0111) begin
      if (nLog[i] < 8) begin
        logCmd[i][nLog[i]] = c; logBa[i][nLog[i]] = b;
        logAddr[i][nLog[i]] = a; logCyc[i][nLog[i]] = cyc;
      end
      nLog[i]++;
    end
    if (c == 4'b0111 && firstNop[i] < 0) firstNop[i] = cyc;
    if (c[3] && firstNop[i] >= 0 && doneRise[i] < 0) deselIn[i]++;
    if (k && !prevCke[i] && ckeRise[i] < 0) ckeRise[i] = cyc;
    prevCke[i] = k;
    if (doneRise[i] >= 0 && (c != 4'b0111 || !d || !k)) postDone[i]++;
    if (d && doneRise[i] < 0) doneRise[i] = cyc;
  endtask

  always @(negedge clk) if (logEn) begin
    mon(0, cmd0, ba0, addr0, cke0, done0);
    mon(1, cmd1, ba1, addr1, cke1, done1);
  end

  function automatic int expAddr(int i, int k);
    if (k == 0) return 1 << 10;
    if (EXP_CMD[k] == 4'b0000) return (EXP_BA[i][k] == 2'd0) ? int'(modeReg) : int'(extModeReg);
    return 0;
  endfunction

  task automatic checkIdle(string req);
    chk({req, " cs u0"}, int'(cmd0), 15); chk({req, " cs u1"}, int'(cmd1), 15);
    chk({req, " cke u0"}, int'(cke0), 0); chk({req, " cke u1"}, int'(cke1), 0);
    chk({req, " done u0"}, int'(done0), 0); chk({req, " done u1"}, int'(done1), 0);
  endtask

  task automatic runToDone();
    for (int n = 0; n < 400 && !(done0 && done1); n++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkRun();
    for (int i = 0; i < 2; i++) begin
      chk($sformatf("R3 count u%0d", i), nLog[i], 5);
      for (int k = 0; k < 5 && k < nLog[i]; k++) begin
        int prev, gap;
        chk($sformatf("R3 cmd%0d u%0d", k, i), int'(logCmd[i][k]), int'(EXP_CMD[k]));
        chk($sformatf("R6 bank%0d u%0d", k, i), int'(logBa[i][k]), int'(EXP_BA[i][k]));
        chk($sformatf("R6 addr%0d u%0d", k, i), int'(logAddr[i][k]), expAddr(i, k));
        prev = (k == 0) ? firstNop[i] : logCyc[i][k-1];
        gap  = (k == 0 && i == 1) ? S + TIS : EXP_GAP[k];
        chk($sformatf("%s gap%0d u%0d", k == 0 ? "R2" : "R4", k, i),
            logCyc[i][k] - prev, gap);
      end
      if (nLog[i] >= 5)
        chk($sformatf("R8 done delay u%0d", i), doneRise[i] - logCyc[i][4], TMRD);
      chk($sformatf("R5 deselect in gaps u%0d", i), deselIn[i], 0);
      chk($sformatf("R8 quiet after done u%0d", i), postDone[i], 0);
    end
    chk("R2 cke with first NOP u0", ckeRise[0], firstNop[0]);
    chk("R7 cke setup before precharge u1", logCyc[1][0] - ckeRise[1], TIS);
    chk("R7 cke low through stable wait u1", ckeRise[1] - firstNop[1], S);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkIdle("R1 powerGood low");

    // run 1: full sequence
    modeReg = 13'h0033; extModeReg = 13'h0020;
    clearLog(); logEn = 1'b1;
    powerGood = 1'b1;
    runToDone();
    logEn = 1'b0;
    checkRun();

    // drop after completion
    powerGood = 1'b0;
    @(negedge clk); @(negedge clk);
    checkIdle("R9 drop after done");

    // run 2: interrupt inside the refresh gap, then restart
    modeReg = 13'h1A5C; extModeReg = 13'h0407;
    powerGood = 1'b1;
    repeat (S + TIS + TRP + 4) @(negedge clk);
    powerGood = 1'b0;
    @(negedge clk); @(negedge clk);
    checkIdle("R9 drop mid sequence");
    clearLog(); logEn = 1'b1;
    powerGood = 1'b1;
    runToDone();
    logEn = 1'b0;
    checkRun();

    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

  initial begin
    #(4 * 20000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

endmodule